// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block is the configuration front end of a multi-function peripheral chip. A host sees two byte-wide locations on its bus, chosen by one address bit: an index location and a data location. Access to the configuration space stays closed after reset. The host opens it by writing the enter key twice in a row to the index location. While open, a write to the index location selects a register number, and the data location then reads or writes that register. Writing the exit key to the index location closes access again.

The register space has two parts. Global registers hold the device identity and a logical-device selector. Registers from 0x30 upward are banked: each logical device has its own copy. The selector picks which copy the data location reaches. Each bank holds an enable bit and a 16-bit base address, and all of them drive output pins so that the functions behind the port can use them.

The key sequencer is a three-state machine. Its states are `KS_LOCKED`, `KS_ARMED` and `KS_OPEN`, and only index-location writes move it. Its transitions are:
- key-first: `KS_LOCKED` to `KS_ARMED` on an index write of 0x87.
- key-second: `KS_ARMED` to `KS_OPEN` on a second index write of 0x87.
- key-broken: `KS_ARMED` to `KS_LOCKED` on an index write of any other value.
- key-exit: `KS_OPEN` to `KS_LOCKED` on an index write of 0xAA.
- Every other index write leaves the state unchanged.

Top module: `cfg_keyport`

## Requirements
- R1: After reset the port is locked, every bank enable and base address output is 0, the logical-device selector is 0 and the latched index is 0.
- R2: Access opens only after 0x87 is written to the index location (`bus_sel`=0) on two consecutive index writes. An index write of any other value after a single 0x87 clears the sequence, so two further 0x87 writes are needed.
- R3: While the port is locked (including the armed state), data-location writes (`bus_sel`=1) change no register and data-location reads return 0xFF.
- R4: While open, an index write of 0xAA closes access and does not change the latched index. Any other index write while open stores the value as the latched index.
- R5: While open, registers 0x20 and 0x21 read the device ID high byte then low byte (default 0x5A17). Register 0x22 reads the revision (default 0x03). Registers 0x23 and 0x24 read the manufacturer ID 0x1934, high byte first.
- R6: Writes to registers 0x20 to 0x24 are ignored.
- R7: Register 0x07 is the 8-bit logical-device selector. It can be written and read back.
- R8: For the selected device, bit 0 of register 0x30 is its enable. Registers 0x60 and 0x61 are the high and low bytes of its base address. `dev_en[i]` and `dev_base[16*i+15:16*i]` show device i.
- R9: A write to a banked register changes only the bank of the device number held in 0x07. Other banks keep their values.
- R10: If the selector is not below NUM_DEV (default 4), banked writes are ignored and banked reads return 0x00.
- R11: A read of the index location returns the latched index while open and 0xFF while locked.
- R12: Register 0x30 stores only bit 0. Its other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | 0 selects the index location, 1 selects the data location |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected location (combinational) |
| dev_en | output | NUM_DEV | Enable bit of each logical device |
| dev_base | output | 16*NUM_DEV | Base address of each logical device |

## Verification
The bench attacks the key sequence with a broken pattern (0x87, another byte, 0x87). A sequencer that did not clear on the middle byte would open early and return a real register where 0xFF is expected. It writes to the data location while locked and after exit, and then reopens the port and reads back. A design that decoded data writes without checking the lock would show a set enable bit. It programs two banks one after the other and selects a device number beyond the last bank. A faulty bank decode would corrupt the first bank or write through an out-of-range selector. It also rewrites the identity registers, where a writable ID would read back wrong. The exit key is checked for leaving the latched index alone.

// File: rtl/cfg_keyport_pkg.sv
package cfg_keyport_pkg;
    typedef enum logic [1:0] {
        KS_LOCKED = 2'd0,
        KS_ARMED  = 2'd1,
        KS_OPEN   = 2'd2
    } key_state_t;

    localparam logic [7:0] RA_LDN     = 8'h07;
    localparam logic [7:0] RA_ID_HI   = 8'h20;
    localparam logic [7:0] RA_ID_LO   = 8'h21;
    localparam logic [7:0] RA_REV     = 8'h22;
    localparam logic [7:0] RA_MFG_HI  = 8'h23;
    localparam logic [7:0] RA_MFG_LO  = 8'h24;
    localparam logic [7:0] RA_ENABLE  = 8'h30;
    localparam logic [7:0] RA_BASE_HI = 8'h60;
    localparam logic [7:0] RA_BASE_LO = 8'h61;
endpackage

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
    import cfg_keyport_pkg::*;
#(
    parameter logic [7:0] ENTER_KEY = 8'h87,
    parameter logic [7:0] EXIT_KEY  = 8'hAA
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       cfg_open,
    output logic [7:0] idx_q
);
    key_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= KS_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KS_LOCKED: if (idx_wr && wdata == ENTER_KEY) state_d = KS_ARMED;
            KS_ARMED:  if (idx_wr) state_d = (wdata == ENTER_KEY) ? KS_OPEN : KS_LOCKED;
            KS_OPEN:   if (idx_wr && wdata == EXIT_KEY) state_d = KS_LOCKED;
            default:   state_d = KS_LOCKED;
        endcase
    end

    always_comb begin
        cfg_open = (state_q == KS_OPEN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idx_q <= 8'h00;
        else if (idx_wr && state_q == KS_OPEN && wdata != EXIT_KEY) idx_q <= wdata;
    end
endmodule

// File: rtl/cfg_ldev_bank.sv
module cfg_ldev_bank
    import cfg_keyport_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  idx,
    input  logic [7:0]  wdata,
    output logic        en,
    output logic [15:0] base
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en   <= 1'b0;
            base <= 16'h0000;
        end else if (wr_en) begin
            if (idx == RA_ENABLE)  en         <= wdata[0];
            if (idx == RA_BASE_HI) base[15:8] <= wdata;
            if (idx == RA_BASE_LO) base[7:0]  <= wdata;
        end
    end
endmodule

// File: rtl/cfg_keyport.sv
module cfg_keyport
    import cfg_keyport_pkg::*;
#(
    parameter int          NUM_DEV = 4,
    parameter logic [15:0] DEV_ID  = 16'h5A17,
    parameter logic [7:0]  DEV_REV = 8'h03,
    parameter logic [15:0] MFG_ID  = 16'h1934
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_sel,
    input  logic                   bus_wr,
    input  logic [7:0]             bus_wdata,
    output logic [7:0]             bus_rdata,
    output logic [NUM_DEV-1:0]     dev_en,
    output logic [16*NUM_DEV-1:0]  dev_base
);
    localparam int LDN_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

    logic        cfg_open;
    logic [7:0]  idx_q;
    logic [7:0]  ldn_q;
    logic        ldn_ok;
    logic        data_wr;
    logic [15:0] base_arr [NUM_DEV];
    logic        sel_en;
    logic [15:0] sel_base;

    cfg_key_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (bus_wr && !bus_sel),
        .wdata    (bus_wdata),
        .cfg_open (cfg_open),
        .idx_q    (idx_q)
    );

    assign data_wr = bus_wr && bus_sel && cfg_open;
    assign ldn_ok  = (ldn_q < 8'(NUM_DEV));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ldn_q <= 8'h00;
        else if (data_wr && idx_q == RA_LDN) ldn_q <= bus_wdata;
    end

    for (genvar i = 0; i < NUM_DEV; i++) begin : g_bank
        cfg_ldev_bank u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (data_wr && ldn_q == 8'(i)),
            .idx   (idx_q),
            .wdata (bus_wdata),
            .en    (dev_en[i]),
            .base  (base_arr[i])
        );
        assign dev_base[16*i +: 16] = base_arr[i];
    end

    always_comb begin
        sel_en   = 1'b0;
        sel_base = 16'h0000;
        if (ldn_ok) begin
            sel_en   = dev_en[ldn_q[LDN_W-1:0]];
            sel_base = base_arr[ldn_q[LDN_W-1:0]];
        end
    end

    always_comb begin
        bus_rdata = 8'hFF;
        if (cfg_open) begin
            if (!bus_sel) begin
                bus_rdata = idx_q;
            end else begin
                unique case (idx_q)
                    RA_LDN:     bus_rdata = ldn_q;
                    RA_ID_HI:   bus_rdata = DEV_ID[15:8];
                    RA_ID_LO:   bus_rdata = DEV_ID[7:0];
                    RA_REV:     bus_rdata = DEV_REV;
                    RA_MFG_HI:  bus_rdata = MFG_ID[15:8];
                    RA_MFG_LO:  bus_rdata = MFG_ID[7:0];
                    RA_ENABLE:  bus_rdata = {7'b0, sel_en};
                    RA_BASE_HI: bus_rdata = sel_base[15:8];
                    RA_BASE_LO: bus_rdata = sel_base[7:0];
                    default:    bus_rdata = 8'h00;
                endcase
            end
        end
    end
endmodule

// File: rtl/cfg_keyport_chk.sv
module cfg_keyport_chk #(
    parameter int NUM_DEV = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_sel,
    input logic                  bus_wr,
    input logic [7:0]            bus_wdata,
    input logic [7:0]            bus_rdata,
    input logic                  cfg_open,
    input logic [7:0]            idx_q,
    input logic [7:0]            ldn_q,
    input logic [NUM_DEV-1:0]    dev_en,
    input logic [16*NUM_DEV-1:0] dev_base
);
    // R2
    open_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_open) |-> $past(bus_wr && !bus_sel && bus_wdata == 8'h87));

    // R2
    wrong_byte_stays_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && bus_wr && !bus_sel && bus_wdata != 8'h87) |=> !cfg_open);

    // R3
    locked_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && bus_wr && bus_sel) |=> ($stable(dev_en) && $stable(dev_base) && $stable(ldn_q)));

    // R3
    locked_read_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && bus_sel) |-> bus_rdata == 8'hFF);

    // R4
    exit_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && bus_wr && !bus_sel && bus_wdata == 8'hAA) |=> (!cfg_open && $stable(idx_q)));

    // R10
    bad_ldn_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && bus_wr && bus_sel && ldn_q >= 8'(NUM_DEV) && idx_q != 8'h07)
        |=> ($stable(dev_en) && $stable(dev_base)));
endmodule

bind cfg_keyport cfg_keyport_chk #(.NUM_DEV(NUM_DEV)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cfg_open  (cfg_open),
    .idx_q     (idx_q),
    .ldn_q     (ldn_q),
    .dev_en    (dev_en),
    .dev_base  (dev_base)
);

// File: tb/cfg_keyport_bench.sv
`timescale 1ns/1ps
module cfg_keyport_bench;
    localparam int ND = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_wdata = 8'h00;
    logic [7:0]    bus_rdata;
    logic [ND-1:0] dev_en;
    logic [16*ND-1:0] dev_base;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cfg_keyport u_cfg_keyport (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dev_en(dev_en), .dev_base(dev_base)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic sel, logic [7:0] d);
        @(negedge clk);
        bus_sel = sel; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic sel, output logic [7:0] d);
        @(negedge clk);
        bus_sel = sel; bus_wr = 1'b0;
        #1 d = bus_rdata;
    endtask

    task automatic reg_wr(logic [7:0] a, logic [7:0] d);
        wr(1'b0, a); wr(1'b1, d);
    endtask

    task automatic reg_rd(logic [7:0] a, output logic [7:0] d);
        wr(1'b0, a); rd(1'b1, d);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        rd(1'b1, d); check("R1 data read after reset", d, 8'hFF);
        rd(1'b0, d); check("R11 index read locked", d, 8'hFF);
        check("R1 dev_en after reset", dev_en, '0);
        check("R1 dev_base after reset", dev_base, '0);
    endtask

    task automatic t_broken_key;
        logic [7:0] d;
        wr(1'b0, 8'h87); wr(1'b0, 8'h55); wr(1'b0, 8'h87);
        rd(1'b1, d); check("R2 broken key stays locked", d, 8'hFF);
        wr(1'b0, 8'h87);
        rd(1'b0, d); check("R2 open after two keys, R11 index 0", d, 8'h00);
        wr(1'b0, 8'h20);
        rd(1'b0, d); check("R11 index read open", d, 8'h20);
    endtask

    task automatic t_ids;
        logic [7:0] d;
        reg_rd(8'h20, d); check("R5 id hi", d, 8'h5A);
        reg_rd(8'h21, d); check("R5 id lo", d, 8'h17);
        reg_rd(8'h22, d); check("R5 rev", d, 8'h03);
        reg_rd(8'h23, d); check("R5 mfg hi", d, 8'h19);
        reg_rd(8'h24, d); check("R5 mfg lo", d, 8'h34);
        reg_wr(8'h20, 8'hFF); reg_rd(8'h20, d); check("R6 id write ignored", d, 8'h5A);
        reg_wr(8'h24, 8'h00); reg_rd(8'h24, d); check("R6 mfg write ignored", d, 8'h34);
    endtask

    task automatic t_banks;
        logic [7:0] d;
        reg_wr(8'h07, 8'h00);
        reg_wr(8'h30, 8'hFF);
        reg_rd(8'h30, d); check("R12 enable reads bit0 only", d, 8'h01);
        reg_wr(8'h60, 8'h12); reg_wr(8'h61, 8'h34);
        check("R8 dev0 base", dev_base[15:0], 16'h1234);
        reg_wr(8'h07, 8'h02);
        reg_rd(8'h07, d); check("R7 selector readback", d, 8'h02);
        reg_rd(8'h30, d); check("R9 dev2 enable still 0", d, 8'h00);
        reg_wr(8'h60, 8'hAB); reg_wr(8'h61, 8'hCD); reg_wr(8'h30, 8'h01);
        reg_rd(8'h60, d); check("R8 dev2 base hi read", d, 8'hAB);
        check("R8 dev_en pins", dev_en, 4'b0101);
        check("R9 dev0 base kept", dev_base[15:0], 16'h1234);
        check("R8 dev2 base pins", dev_base[47:32], 16'hABCD);
    endtask

    task automatic t_bad_ldn;
        logic [7:0] d;
        reg_wr(8'h07, 8'h09);
        reg_wr(8'h30, 8'h00); reg_wr(8'h60, 8'h77);
        check("R10 enables unchanged", dev_en, 4'b0101);
        check("R10 bases unchanged", dev_base, {16'h0, 16'hABCD, 16'h0, 16'h1234});
        reg_wr(8'h07, 8'h09);
        reg_rd(8'h61, d); check("R10 banked read zero", d, 8'h00);
    endtask

    task automatic t_exit_and_locked;
        logic [7:0] d;
        reg_wr(8'h07, 8'h01);
        wr(1'b0, 8'h30);
        wr(1'b0, 8'hAA);
        rd(1'b1, d); check("R4 exit closes", d, 8'hFF);
        wr(1'b1, 8'h01);
        wr(1'b0, 8'h87);
        wr(1'b1, 8'h01);
        rd(1'b1, d); check("R3 armed data read FF", d, 8'hFF);
        check("R3 locked write no effect", dev_en, 4'b0101);
        wr(1'b0, 8'h87);
        rd(1'b0, d); check("R4 index kept over exit", d, 8'h30);
        rd(1'b1, d); check("R3 dev1 enable still 0", d, 8'h00);
        wr(1'b0, 8'hAA);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_broken_key();
        t_ids();
        t_banks();
        t_bad_ldn();
        t_exit_and_locked();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog R1 actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule